// File: doc/BRIEF.md
# Voice interrupt priority encoder

This block gathers pending interrupts from a bank of synthesis voices. Two event sources are tracked for each voice: the end of a wavetable pass and the completion of a volume ramp. Each source has its own pending vector. A one-cycle pulse on a voice's set line marks that voice pending. Together, the two vectors drive two summary bits in a global status byte and a single interrupt line.

Software services the voices one at a time. It writes the acknowledge function code 0x8F to the function-select register. In that write cycle the block picks one pending voice. Any wavetable interrupt beats every volume-ramp interrupt, and within a source the lowest voice number wins. The block clears the chosen voice's pending bit and emits a one-cycle clear pulse to that voice's control-register bit 7. It also stores an encoded status byte, which software reads back through the data register while the function select still holds 0x8F. Once both vectors are empty, the summary bits and the interrupt line fall.

Top module: `voice_irq_prio`

## Requirements
- R1: After reset, both pending vectors are empty, the function select reads 0x00, the global status reads 0x00, irq_o is low and no clear pulse is active.
- R2: A set pulse on voice k of either source marks it pending. Global status bit 5 is high while any wavetable voice is pending, and bit 6 is high while any ramp voice is pending. irq_o is high while the global status is non-zero.
- R3: A scan happens only on a write of 0x8F to address 0 (function select). Other function codes, and writes of 0x8F to any other address, leave the pending state and the status byte unchanged.
- R4: On a scan with any wavetable voice pending, the lowest pending wavetable voice v is cleared and the status byte becomes 0x60 | v.
- R5: A scan looks at volume-ramp voices only when no wavetable voice is pending. It then clears the lowest pending ramp voice v and sets the status byte to 0x80 | v.
- R6: A scan with nothing pending sets the status byte to 0xE8, which is also its reset value.
- R7: During the scan write cycle, exactly one bit of wt_ctl_clr_o (wavetable) or ramp_ctl_clr_o (ramp) is high, at the acknowledged voice's position. The bit drives the clear of bit 7 in that voice's matching control register. No clear bit is high otherwise.
- R8: When the last voice of a source is acknowledged, the matching global status bit falls. Once both bits are zero, irq_o drops.
- R9: Reading address 1 while the function select holds 0x8F returns the last status byte. Reading changes nothing. Address 1 reads 0x00 under any other function select, and address 2 returns the global status.
- R10: A set pulse in the same cycle as the acknowledge of the same voice and source leaves that voice pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_set_i | input | 31 | Per-voice wavetable-end set pulses |
| ramp_set_i | input | 31 | Per-voice volume-ramp set pulses |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 function select, 1 data, 2 global status |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational) |
| wt_ctl_clr_o | output | 31 | Clear pulse for bit 7 of each voice's first control register |
| ramp_ctl_clr_o | output | 31 | Clear pulse for bit 7 of each voice's ramp control register |
| irq_o | output | 1 | Interrupt request |

## Verification
A new voice event and the acknowledge of that same voice can land in the same clock cycle. In that case the set path and the clear path drive the same pending bit. The bench raises the set pulse for the voice that the scan is about to pick, in the same cycle as the 0x8F write. It then checks that the clear pulse was still emitted and that the status byte names that voice. It also checks that global status bit 5 stays high and that the next scan acknowledges the same voice again. A second overlap also gets the bench's attention: a wavetable event and a ramp event pending at the same time. Here the bench checks that the wavetable voice is served first, even though the ramp voice has the lower number.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;
  localparam logic [7:0] FN_ACK     = 8'h8F;
  localparam logic [7:0] CODE_WT    = 8'h60;
  localparam logic [7:0] CODE_RAMP  = 8'h80;
  localparam logic [7:0] CODE_IDLE  = 8'hE8;
  localparam int         GST_WT_BIT   = 5;
  localparam int         GST_RAMP_BIT = 6;
  localparam int         NUM_SRC      = 2;
  localparam int         SRC_WT       = 0;
  localparam int         SRC_RAMP     = 1;

  typedef enum logic [1:0] {
    ADR_FSEL = 2'd0,
    ADR_DATA = 2'd1,
    ADR_GST  = 2'd2,
    ADR_NONE = 2'd3
  } reg_adr_e;
endpackage

// File: rtl/voice_irq_lowest.sv
module voice_irq_lowest #(
  parameter int W  = 31,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic [W-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign onehot_o = req_i & (~req_i + {{(W-1){1'b0}}, 1'b1});
  assign any_o    = |req_i;
endmodule

// File: rtl/voice_irq_bank.sv
module voice_irq_bank #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q, pend_d;
  logic         upd_en;

  always_comb begin
    pend_d = (pend_q & ~clr_i) | set_i;
    upd_en = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R10

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0)); // R4
endmodule

// File: rtl/voice_irq_prio.sv
module voice_irq_prio
  import voice_irq_pkg::*;
#(
  parameter int NV = 31,
  localparam int IW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] wt_set_i,
  input  logic [NV-1:0] ramp_set_i,
  input  logic          bus_wr_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  output logic [NV-1:0] wt_ctl_clr_o,
  output logic [NV-1:0] ramp_ctl_clr_o,
  output logic          irq_o
);
  logic [NUM_SRC-1:0][NV-1:0] set_v, clr_v, pend_v, oh_v;
  logic [NUM_SRC-1:0][IW-1:0] idx_v;
  logic [NUM_SRC-1:0]         any_v;

  logic [7:0] fsel_q, fsel_d, stat_q, stat_d, gstat;
  logic       fsel_en, scan;

  assign set_v[SRC_WT]   = wt_set_i;
  assign set_v[SRC_RAMP] = ramp_set_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    voice_irq_bank #(.W(NV)) i_bank (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[s]), .clr_i(clr_v[s]), .pend_o(pend_v[s])
    );
    voice_irq_lowest #(.W(NV), .IW(IW)) i_low (
      .req_i(pend_v[s]), .onehot_o(oh_v[s]), .idx_o(idx_v[s]), .any_o(any_v[s])
    );
  end

  always_comb begin
    scan    = bus_wr_i && (bus_addr_i == ADR_FSEL) && (bus_wdata_i == FN_ACK);
    fsel_en = bus_wr_i && (bus_addr_i == ADR_FSEL);
    fsel_d  = bus_wdata_i;
    clr_v   = '0;
    stat_d  = stat_q;
    if (scan) begin
      if (any_v[SRC_WT]) begin
        clr_v[SRC_WT] = oh_v[SRC_WT];
        stat_d        = CODE_WT | 8'(idx_v[SRC_WT]);
      end else if (any_v[SRC_RAMP]) begin
        clr_v[SRC_RAMP] = oh_v[SRC_RAMP];
        stat_d          = CODE_RAMP | 8'(idx_v[SRC_RAMP]);
      end else begin
        stat_d = CODE_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fsel_q <= '0;
    else if (fsel_en) fsel_q <= fsel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= CODE_IDLE;
    else if (scan) stat_q <= stat_d;
  end

  always_comb begin
    gstat               = '0;
    gstat[GST_WT_BIT]   = any_v[SRC_WT];
    gstat[GST_RAMP_BIT] = any_v[SRC_RAMP];
    case (bus_addr_i)
      ADR_FSEL: bus_rdata_o = fsel_q;
      ADR_DATA: bus_rdata_o = (fsel_q == FN_ACK) ? stat_q : 8'h00;
      ADR_GST:  bus_rdata_o = gstat;
      default:  bus_rdata_o = 8'h00;
    endcase
  end

  assign wt_ctl_clr_o   = clr_v[SRC_WT];
  assign ramp_ctl_clr_o = clr_v[SRC_RAMP];
  assign irq_o          = |gstat;

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wt_ctl_clr_o, ramp_ctl_clr_o})); // R7

  AST_NO_SCAN_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_i && bus_addr_i == 2'd0 && bus_wdata_i == 8'h8F)
      |-> (wt_ctl_clr_o == '0 && ramp_ctl_clr_o == '0)); // R3

  AST_RAMP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ramp_ctl_clr_o) |-> (pend_v[SRC_WT] == '0)); // R5

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_i && bus_addr_i == 2'd0 && bus_wdata_i == 8'h8F) |=> $stable(stat_q)); // R9

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd0 && bus_wdata_i == 8'h8F
     && pend_v[SRC_WT] == '0 && pend_v[SRC_RAMP] == '0) |=> (stat_q == 8'hE8)); // R6
endmodule

// File: tb/test_voice_irq_prio.sv
module test_voice_irq_prio;
  localparam int NV = 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] wt_set = '0, ramp_set = '0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd3;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NV-1:0] wt_clr, ramp_clr;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  voice_irq_prio #(.NV(NV)) i_voice_irq_prio (
    .clk(clk), .rst_n(rst_n), .wt_set_i(wt_set), .ramp_set_i(ramp_set),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .wt_ctl_clr_o(wt_clr), .ramp_ctl_clr_o(ramp_clr),
    .irq_o(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #2;
    check(tag, 64'(bus_rdata), 64'(exp));
    bus_addr = 2'd3;
  endtask

  task automatic pulse(input logic [NV-1:0] w, input logic [NV-1:0] r);
    @(negedge clk);
    wt_set = w; ramp_set = r;
    @(negedge clk);
    wt_set = '0; ramp_set = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd3;
  endtask

  // scan write, checking clear pulses inside the write cycle, then the status byte
  task automatic ack(input logic [NV-1:0] exp_wt, input logic [NV-1:0] exp_rp,
                     input logic [7:0] exp_stat, input logic [NV-1:0] same_wt, input string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h8F; wt_set = same_wt;
    #2;
    check({tag, " R7 wt clear"}, 64'(wt_clr), 64'(exp_wt));
    check({tag, " R7 ramp clear"}, 64'(ramp_clr), 64'(exp_rp));
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd3; wt_set = '0;
    #2;
    check({tag, " R7 pulse ends"}, 64'({wt_clr, ramp_clr}), 64'(0));
    rd(2'd1, exp_stat, {tag, " status"});
  endtask

  task automatic t_reset;
    rd(2'd0, 8'h00, "R1 fsel");
    rd(2'd2, 8'h00, "R1 gstat");
    check("R1 irq", 64'(irq), 64'(0));
    check("R1 clears", 64'({wt_clr, ramp_clr}), 64'(0));
  endtask

  task automatic t_set_and_nonscan;
    pulse((NV'(1) << 3) | (NV'(1) << 17), NV'(1) << 5);
    rd(2'd2, 8'h60, "R2 gstat both");
    check("R2 irq", 64'(irq), 64'(1));
    wr(2'd0, 8'h41);
    rd(2'd1, 8'h00, "R9 data with other fsel");
    wr(2'd1, 8'h8F);
    rd(2'd2, 8'h60, "R3 no scan gstat");
    rd(2'd0, 8'h41, "R3 fsel kept");
  endtask

  task automatic t_drain;
    ack(NV'(1) << 3, '0, 8'h63, '0, "R4 first wt");
    rd(2'd1, 8'h63, "R9 reread");
    ack(NV'(1) << 17, '0, 8'h71, '0, "R4 second wt");
    rd(2'd2, 8'h40, "R8 wt bit falls");
    ack('0, NV'(1) << 5, 8'h85, '0, "R5 ramp");
    rd(2'd2, 8'h00, "R8 gstat empty");
    check("R8 irq low", 64'(irq), 64'(0));
    ack('0, '0, 8'hE8, '0, "R6 idle");
  endtask

  task automatic t_priority;
    pulse(NV'(1) << 20, NV'(1) << 1);
    ack(NV'(1) << 20, '0, 8'h74, '0, "R5 wt beats ramp");
    ack('0, NV'(1) << 1, 8'h81, '0, "R5 ramp after");
    pulse(NV'(1), '0);
    ack(NV'(1), '0, 8'h60, '0, "R4 voice 0");
  endtask

  task automatic t_collision;
    pulse(NV'(1) << 30, '0);
    ack(NV'(1) << 30, '0, 8'h7E, NV'(1) << 30, "R10 set with ack");
    rd(2'd2, 8'h20, "R10 still pending");
    ack(NV'(1) << 30, '0, 8'h7E, '0, "R10 reacked");
    rd(2'd2, 8'h00, "R10 drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set_and_nonscan();
    t_drain();
    t_priority();
    t_collision();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule